// File: doc/BRIEF.md
# Full-Speed Frame Timer

This block keeps time for a full-speed host bus. It counts bit times down from a programmable frame length and reloads the count at each frame boundary. Each time the count wraps, it raises a one-cycle start-of-frame pulse and moves a 16-bit frame number on by one. It raises a second pulse whenever the most significant bit of the frame number changes. It raises a third pulse when the count reaches a programmable point inside the frame where periodic work is to begin.

The count advances only on a 12 MHz bit-time enable and only while the host is operational. When the host enters the operational state, the counter is loaded from the interval. The driver sets the interval length together with a toggle bit. The toggle is copied next to the running count on each wrap, so software can see which interval is in force. A largest-packet budget counter is loaded at every frame start and runs down with the bit ticks. A low-speed threshold register is also kept here for the transfer logic.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, remain, remain_tgl, frame_num, pkt_cnt, ls_thr and all three pulse outputs are zero.
- R2: While operational, remain goes down by one on each cycle with bit_tick high, and holds on cycles with bit_tick low.
- R3: On a tick with remain at 0, remain reloads from the interval. An interval written in the middle of a frame is first used at the next reload.
- R4: On each reload at zero, remain_tgl takes the toggle bit held at wr_data[31] of the last frame-word write. Before that reload it keeps its old value.
- R5: frame_num increments on each reload at zero and wraps from 16'hFFFF to 16'h0000.
- R6: fno_pulse is high for one cycle, together with the new frame number, whenever bit 15 of frame_num changes (both 0 to 1 and 1 to 0).
- R7: sof_pulse is high for exactly the one cycle in which the reloaded count and the new frame number first appear.
- R8: pkt_cnt loads the largest-packet value at each frame start and on entry to operation. It drops by one on each decrement tick and stops at 0.
- R9: pstart_pulse is high in the cycle after a decrement that brought remain to the periodic-start value. A reload never raises it.
- R10: While run is low, remain, remain_tgl and frame_num hold, and no pulse is produced.
- R11: On the first cycle with run high after run was low, remain loads from the interval. frame_num is unchanged and no pulse is produced, whether or not bit_tick is high.
- R12: A write with wr_en high takes effect at that clock edge. wr_sel 0 is the frame word: interval in bits 13:0, largest-packet value in bits 30:16, toggle in bit 31. wr_sel 1 holds the periodic-start value in bits 13:0. wr_sel 2 holds the low-speed threshold in bits 11:0, which drives ls_thr. wr_sel 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | 12 MHz bit-time enable |
| run | input | 1 | Host is in the operational state |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| remain | output | 14 | Bit times left in the frame |
| remain_tgl | output | 1 | Copy of the interval toggle |
| frame_num | output | 16 | Frame number |
| sof_pulse | output | 1 | Start-of-frame pulse |
| fno_pulse | output | 1 | Frame number bit-15 change pulse |
| pstart_pulse | output | 1 | Periodic start point reached |
| pkt_cnt | output | 15 | Largest-packet budget counter |
| ls_thr | output | 12 | Low-speed threshold value |

## Verification
Every result of this block comes from a register. A write, tick, entry or stop therefore shows at the outputs one clock edge after the cycle that carries it: the pulses, the reloaded count, the frame number and the budget all appear together after the wrap edge. The bench drives inputs on the falling edge and samples on the next falling edge. Expected values are formulas in the number of ticks since entry (count modulo interval plus one, frame index by division), so each sample is compared with the state due exactly one edge later. Long stretches, such as the full 65536-frame wrap with a zero interval, are checked on every cycle.

// File: rtl/usbft_pkg.sv
`timescale 1ns/1ps
package usbft_pkg;
  typedef enum logic [1:0] {
    SEL_FRAME  = 2'd0,
    SEL_PSTART = 2'd1,
    SEL_LSTHR  = 2'd2,
    SEL_NONE   = 2'd3
  } usbft_sel_e;

  localparam int TGL_BIT = 31;
  localparam int PKT_LSB = 16;
endpackage

// File: rtl/usbft_cfg.sv
`timescale 1ns/1ps
module usbft_cfg #(
  parameter int CNT_W   = 14,
  parameter int PKT_W   = 15,
  parameter int LS_W    = 12,
  parameter int DATA_W  = 32,
  parameter int DEF_IVL = 11999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  ivl,
  output logic              ivl_tgl,
  output logic [PKT_W-1:0]  pkt_max,
  output logic [CNT_W-1:0]  pstart,
  output logic [LS_W-1:0]   ls_thr
);
  import usbft_pkg::*;

  usbft_sel_e sel;
  assign sel = usbft_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl     <= CNT_W'(DEF_IVL);
      ivl_tgl <= 1'b0;
      pkt_max <= '0;
      pstart  <= '0;
      ls_thr  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_FRAME: begin
          ivl     <= wr_data[CNT_W-1:0];
          pkt_max <= wr_data[PKT_LSB +: PKT_W];
          ivl_tgl <= wr_data[TGL_BIT];
        end
        SEL_PSTART: pstart <= wr_data[CNT_W-1:0];
        SEL_LSTHR:  ls_thr <= wr_data[LS_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/usbft_remain.sv
`timescale 1ns/1ps
module usbft_remain #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             run,
  input  logic [CNT_W-1:0] ivl,
  input  logic             ivl_tgl,
  input  logic [CNT_W-1:0] pstart,
  output logic [CNT_W-1:0] remain,
  output logic             remain_tgl,
  output logic             ev_enter,
  output logic             ev_wrap,
  output logic             ev_step,
  output logic             pstart_pulse
);
  logic run_q;
  logic ev_active;

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  assign ev_enter  = run & ~run_q;
  assign ev_active = run & run_q & bit_tick;
  assign ev_wrap   = ev_active & (remain == '0);
  assign ev_step   = ev_active & (remain != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      remain       <= '0;
      remain_tgl   <= 1'b0;
      pstart_pulse <= 1'b0;
    end else begin
      run_q        <= run;
      pstart_pulse <= 1'b0;
      if (ev_enter) begin
        remain <= ivl;
      end else if (ev_wrap) begin
        remain     <= ivl;
        remain_tgl <= ivl_tgl;
      end else if (ev_step) begin
        remain       <= count_down(remain);
        pstart_pulse <= (count_down(remain) == pstart);
      end
    end
  end
endmodule

// File: rtl/usbft_fnum.sv
`timescale 1ns/1ps
module usbft_fnum #(
  parameter int FN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_wrap,
  output logic [FN_W-1:0] frame_num,
  output logic            sof_pulse,
  output logic            fno_pulse
);
  function automatic logic [FN_W-1:0] bump(input logic [FN_W-1:0] v);
    return v + FN_W'(1);
  endfunction

  function automatic logic msb_moved(input logic [FN_W-1:0] a, input logic [FN_W-1:0] b);
    return a[FN_W-1] ^ b[FN_W-1];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_num <= '0;
      sof_pulse <= 1'b0;
      fno_pulse <= 1'b0;
    end else begin
      sof_pulse <= ev_wrap;
      fno_pulse <= ev_wrap & msb_moved(frame_num, bump(frame_num));
      if (ev_wrap) frame_num <= bump(frame_num);
    end
  end
endmodule

// File: rtl/usbft_pkt.sv
`timescale 1ns/1ps
module usbft_pkt #(
  parameter int PKT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [PKT_W-1:0] pkt_max,
  output logic [PKT_W-1:0] pkt_cnt
);
  function automatic logic [PKT_W-1:0] drain(input logic [PKT_W-1:0] v);
    return (v == '0) ? v : v - PKT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     pkt_cnt <= '0;
    else if (load)  pkt_cnt <= pkt_max;
    else if (step)  pkt_cnt <= drain(pkt_cnt);
  end
endmodule

// File: rtl/usb_frame_timer.sv
`timescale 1ns/1ps
module usb_frame_timer #(
  parameter int CNT_W   = 14,
  parameter int FN_W    = 16,
  parameter int PKT_W   = 15,
  parameter int LS_W    = 12,
  parameter int DATA_W  = 32,
  parameter int DEF_IVL = 11999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              run,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  remain,
  output logic              remain_tgl,
  output logic [FN_W-1:0]   frame_num,
  output logic              sof_pulse,
  output logic              fno_pulse,
  output logic              pstart_pulse,
  output logic [PKT_W-1:0]  pkt_cnt,
  output logic [LS_W-1:0]   ls_thr
);
  logic [CNT_W-1:0] cfg_ivl;
  logic             cfg_tgl;
  logic [PKT_W-1:0] cfg_pkt;
  logic [CNT_W-1:0] cfg_pstart;
  logic             ev_enter;
  logic             ev_wrap;
  logic             ev_step;

  usbft_cfg #(
    .CNT_W(CNT_W), .PKT_W(PKT_W), .LS_W(LS_W), .DATA_W(DATA_W), .DEF_IVL(DEF_IVL)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ivl(cfg_ivl), .ivl_tgl(cfg_tgl), .pkt_max(cfg_pkt), .pstart(cfg_pstart),
    .ls_thr(ls_thr)
  );

  usbft_remain #(.CNT_W(CNT_W)) u_remain (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run),
    .ivl(cfg_ivl), .ivl_tgl(cfg_tgl), .pstart(cfg_pstart),
    .remain(remain), .remain_tgl(remain_tgl),
    .ev_enter(ev_enter), .ev_wrap(ev_wrap), .ev_step(ev_step),
    .pstart_pulse(pstart_pulse)
  );

  usbft_fnum #(.FN_W(FN_W)) u_fnum (
    .clk(clk), .rst_n(rst_n), .ev_wrap(ev_wrap),
    .frame_num(frame_num), .sof_pulse(sof_pulse), .fno_pulse(fno_pulse)
  );

  usbft_pkt #(.PKT_W(PKT_W)) u_pkt (
    .clk(clk), .rst_n(rst_n), .load(ev_enter | ev_wrap), .step(ev_step),
    .pkt_max(cfg_pkt), .pkt_cnt(pkt_cnt)
  );
endmodule

// File: rtl/usbft_checker.sv
`timescale 1ns/1ps
module usbft_checker #(
  parameter int CNT_W = 14,
  parameter int FN_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             run,
  input logic [CNT_W-1:0] ivl,
  input logic             ivl_tgl,
  input logic [CNT_W-1:0] pstart,
  input logic [CNT_W-1:0] remain,
  input logic             remain_tgl,
  input logic [FN_W-1:0]  frame_num,
  input logic             sof_pulse,
  input logic             fno_pulse,
  input logic             pstart_pulse
);
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && bit_tick && remain != '0) |=> remain == CNT_W'($past(remain) - 1'b1));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && bit_tick && remain == '0) |=> remain == $past(ivl));

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && bit_tick && remain == '0) |=> remain_tgl == $past(ivl_tgl));

  p_fnum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && bit_tick && remain == '0) |=> frame_num == FN_W'($past(frame_num) + 1'b1));

  p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fno_pulse |-> (sof_pulse && frame_num[FN_W-2:0] == '0));

  p_sof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> $changed(frame_num));

  p_pstart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pstart_pulse |-> remain == $past(pstart));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(remain) && $stable(frame_num) && !sof_pulse && !fno_pulse && !pstart_pulse));

  p_enter_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |=> (remain == $past(ivl) && $stable(frame_num) && !sof_pulse));
endmodule

bind usb_frame_timer usbft_checker #(.CNT_W(CNT_W), .FN_W(FN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run),
  .ivl(cfg_ivl), .ivl_tgl(cfg_tgl), .pstart(cfg_pstart),
  .remain(remain), .remain_tgl(remain_tgl), .frame_num(frame_num),
  .sof_pulse(sof_pulse), .fno_pulse(fno_pulse), .pstart_pulse(pstart_pulse)
);

// File: tb/usb_frame_timer_bench.sv
`timescale 1ns/1ps
module usb_frame_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [13:0] remain;
  logic        remain_tgl;
  logic [15:0] frame_num;
  logic        sof_pulse, fno_pulse, pstart_pulse;
  logic [14:0] pkt_cnt;
  logic [11:0] ls_thr;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_frame_timer u_usb_frame_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .remain(remain), .remain_tgl(remain_tgl), .frame_num(frame_num),
    .sof_pulse(sof_pulse), .fno_pulse(fno_pulse), .pstart_pulse(pstart_pulse),
    .pkt_cnt(pkt_cnt), .ls_thr(ls_thr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0;
  endtask

  function automatic logic [31:0] frame_word(input int ivl, input int pkt, input bit tgl);
    return {tgl, 15'(pkt), 2'b00, 14'(ivl)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 remain", remain, 0);
    chk("R1 tgl", remain_tgl, 0);
    chk("R1 fnum", frame_num, 0);
    chk("R1 pulses", {sof_pulse, fno_pulse, pstart_pulse}, 0);
    chk("R1 pkt", pkt_cnt, 0);
    chk("R1 ls", ls_thr, 0);

    // R12 register layout
    wr(2'd2, 32'hFFFF_F5A5);
    chk("R12 ls write", ls_thr, 12'h5A5);
    wr(2'd3, 32'h0000_0123);
    chk("R12 sel3 ignored", ls_thr, 12'h5A5);
    wr(2'd1, 32'd4);
    wr(2'd0, frame_word(9, 5, 1'b1));
    chk("R10 idle remain", remain, 0);

    // R2 R3 R4 R5 R7 R8 R9 R11 sweep with interval 9
    bit_tick = 1'b1; run = 1'b1;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      chk("R2 R3 remain", remain, 9 - (n % 10));
      chk("R5 fnum", frame_num, n / 10);
      chk("R7 R11 sof", sof_pulse, (n > 0 && n % 10 == 0) ? 1 : 0);
      chk("R4 tgl", remain_tgl, (n >= 10) ? 1 : 0);
      chk("R9 pstart", pstart_pulse, (n % 10 == 5) ? 1 : 0);
      chk("R8 pkt", pkt_cnt, (n % 10 <= 5) ? 5 - (n % 10) : 0);
    end

    // R2 no tick: hold
    bit_tick = 1'b0;
    wr(2'd0, frame_word(3, 2, 1'b0));
    repeat (3) @(negedge clk);
    chk("R2 hold remain", remain, 0);
    chk("R2 hold fnum", frame_num, 3);
    bit_tick = 1'b1;
    @(negedge clk);
    chk("R3 new ivl", remain, 3);
    chk("R4 tgl copy 0", remain_tgl, 0);
    chk("R5 fnum 4", frame_num, 4);
    chk("R8 pkt load", pkt_cnt, 2);
    chk("R7 sof", sof_pulse, 1);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R2 remain", remain, 3 - k);
      chk("R9 no pstart", pstart_pulse, 0);
    end
    @(negedge clk);
    chk("R3 reload 3", remain, 3);
    chk("R5 fnum 5", frame_num, 5);

    // R3 mid-frame interval write used at next reload only
    bit_tick = 1'b0;
    wr(2'd0, frame_word(6, 2, 1'b1));
    bit_tick = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R3 old frame", remain, 3 - k);
      chk("R4 tgl kept", remain_tgl, 0);
    end
    @(negedge clk);
    chk("R3 next reload", remain, 6);
    chk("R4 tgl copy 1", remain_tgl, 1);
    chk("R5 fnum 6", frame_num, 6);
    @(negedge clk);
    chk("R9 before pstart", pstart_pulse, 0);
    @(negedge clk);
    chk("R9 pstart at 4", pstart_pulse, 1);
    chk("R9 remain 4", remain, 4);

    // R10 stop operation
    run = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 remain", remain, 4);
      chk("R10 fnum", frame_num, 6);
      chk("R10 pulses", {sof_pulse, fno_pulse, pstart_pulse}, 0);
    end
    // R11 re-entry
    run = 1'b1;
    @(negedge clk);
    chk("R11 load", remain, 6);
    chk("R11 fnum", frame_num, 6);
    chk("R11 no sof", sof_pulse, 0);
    chk("R11 tgl", remain_tgl, 1);

    // R5 R6 full frame-number wrap with zero interval
    run = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset again", frame_num, 0);
    wr(2'd0, frame_word(0, 0, 1'b0));
    run = 1'b1;
    @(negedge clk);
    chk("R11 zero ivl", remain, 0);
    for (int n = 1; n <= 65536; n++) begin
      @(negedge clk);
      chk("R5 wrap count", frame_num, n % 65536);
      chk("R6 fno", fno_pulse, (n == 32768 || n == 65536) ? 1 : 0);
    end
    chk("R7 sof each", sof_pulse, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule